// File: doc/BRIEF.md
# Eight-Pin Parallel Port with Alternate-Function Override

This block runs one byte-wide general-purpose I/O port. A small register bus reaches a data latch, a direction register and three per-pin pad controls: pull-up, slew limit and drive boost. Each pin can also be claimed by an analog converter input, a timer channel or another shared peripheral. These are modelled here as enable, output-enable and data signals. A fixed per-pin priority decides which source drives the pad's output value and output enable, and whether the pull-up is applied.

Reads of the data address return a per-pin mix. A pin that is a plain GPIO output reads back its latch. A pin in analog mode reads 0. Every other pin reads its pad level after a two-flop synchronizer. Writes to the data latch always land, even while a peripheral owns the pin, so the GPIO value is already in place when the override is lifted.

Top module: `gpio_port_ovr`

## Requirements
- R1: After reset, all five registers read 0 and every pin has pad_oe=0 and pad_pull=0.
- R2: With bus_sel=1, register addresses are: 0 data latch, 1 direction (1=output), 2 pull-up enable, 3 slew limit, 4 drive boost. A write to addresses 1 to 4 is read back unchanged. Addresses 5 to 7 read 0 and writes to them change nothing. With bus_sel=0, bus_rdata is 0.
- R3: A pin with ana_en set has pad_oe=0, pad_out=0 and pad_pull=0, and reads 0 at address 0, whatever the other inputs are.
- R4: A pin with tmr_en set and ana_en clear takes pad_oe from tmr_oe and pad_out from tmr_out. Its direction bit has no effect.
- R5: A pin with per_en set and neither ana_en nor tmr_en set takes pad_oe from per_oe and pad_out from per_out.
- R6: A pin with none of the three enables set takes pad_oe from its direction bit and pad_out from its data latch bit.
- R7: Priority per pin is analog over timer over shared peripheral over GPIO, and it holds in mixed patterns across the byte.
- R8: At address 0, a GPIO-mode pin with direction 1 reads its latch bit, and a non-analog pin in any other case reads its synchronized pad input.
- R9: A change on pad_in shows at address 0 after the second rising clock edge, and not after the first.
- R10: A data-latch write while the pin is overridden is kept, and it drives pad_out once the override is released.
- R11: pad_pull is 1 only when the pull-up bit is set, the pin's effective output enable is 0 and the pin is not in analog mode.
- R12: pad_slew and pad_drive follow their registers in every pin mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe, used while bus_sel is 1 |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| ana_en | input | 8 | Per-pin analog input enable |
| tmr_en | input | 8 | Per-pin timer channel enable |
| tmr_oe | input | 8 | Timer output enable per pin |
| tmr_out | input | 8 | Timer output value per pin |
| per_en | input | 8 | Per-pin shared-peripheral enable |
| per_oe | input | 8 | Shared-peripheral output enable per pin |
| per_out | input | 8 | Shared-peripheral output value per pin |
| pad_in | input | 8 | Raw pad input levels |
| pad_out | output | 8 | Value driven onto each pad |
| pad_oe | output | 8 | Pad output driver enable |
| pad_pull | output | 8 | Pad pull-up enable |
| pad_slew | output | 8 | Pad slew limit control |
| pad_drive | output | 8 | Pad drive boost control |

## Verification
The bench uses mixed enable patterns in which several sources claim pins of the same byte at once. A priority inversion, for example shared over timer, would give a wrong output enable on exactly those pins. It checks the pull-up on timer and shared pins whose peripheral leaves them as inputs. A design that gated the pull-up on the direction register instead of the effective direction would get those pins wrong. Read-back is sampled one and two edges after a pad change, which exposes a missing or extra synchronizer stage. A latch written during a timer override is released afterwards, which catches a design that blocks data writes while a pin is overridden.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    MODE_GPIO   = 2'd0,
    MODE_SHARED = 2'd1,
    MODE_TIMER  = 2'd2,
    MODE_ANALOG = 2'd3
  } pin_mode_e;

  localparam int ADDR_W     = 3;
  localparam int NUM_REGS   = 5;
  localparam logic [ADDR_W-1:0] A_DATA  = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIR   = 3'd1;
  localparam logic [ADDR_W-1:0] A_PULL  = 3'd2;
  localparam logic [ADDR_W-1:0] A_SLEW  = 3'd3;
  localparam logic [ADDR_W-1:0] A_DRIVE = 3'd4;

  // fixed priority: analog, timer, shared, gpio
  function automatic pin_mode_e pick_mode(input logic ana, input logic tmr,
                                          input logic per);
    if (ana)      return MODE_ANALOG;
    else if (tmr) return MODE_TIMER;
    else if (per) return MODE_SHARED;
    else          return MODE_GPIO;
  endfunction

  // read-back value of one pin at the data address
  function automatic logic read_bit(input pin_mode_e m, input logic dir,
                                    input logic latch, input logic synced);
    if (m == MODE_ANALOG)                return 1'b0;
    else if (m == MODE_GPIO && dir)      return latch;
    else                                 return synced;
  endfunction
endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      latch_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      pull_q,
  output logic [W-1:0]      slew_q,
  output logic [W-1:0]      drive_q,
  output logic [W-1:0]      cfg_rdata
);
  logic [W-1:0] regs_q [NUM_REGS];
  logic [NUM_REGS-1:0] hit;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    assign hit[r] = wr_en && (addr == ADDR_W'(r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      regs_q[r] <= '0;
      else if (hit[r]) regs_q[r] <= wdata;
    end
  end

  assign latch_q = regs_q[A_DATA];
  assign dir_q   = regs_q[A_DIR];
  assign pull_q  = regs_q[A_PULL];
  assign slew_q  = regs_q[A_SLEW];
  assign drive_q = regs_q[A_DRIVE];

  always_comb begin
    cfg_rdata = '0;
    unique case (addr)
      A_DIR:   cfg_rdata = dir_q;
      A_PULL:  cfg_rdata = pull_q;
      A_SLEW:  cfg_rdata = slew_q;
      A_DRIVE: cfg_rdata = drive_q;
      default: cfg_rdata = '0;
    endcase
  end

  // R10: data write always lands, whatever the pin modes
  p_latch_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hit[A_DATA] |=> latch_q == $past(wdata));
  // R2: writes outside the map leave the direction register alone
  p_unmapped_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr >= ADDR_W'(NUM_REGS)) |=> $stable(dir_q));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;

  // R9: output trails the first stage by exactly one edge
  p_two_stage_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> stage2_q == $past(stage1_q));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ana_en,
  input  logic [W-1:0] tmr_en,
  input  logic [W-1:0] tmr_oe,
  input  logic [W-1:0] tmr_out,
  input  logic [W-1:0] per_en,
  input  logic [W-1:0] per_oe,
  input  logic [W-1:0] per_out,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] latch_q,
  input  logic [W-1:0] pull_q,
  input  logic [W-1:0] synced,
  output logic [W-1:0] out_v,
  output logic [W-1:0] oe_v,
  output logic [W-1:0] pull_v,
  output logic [W-1:0] rd_v
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    pin_mode_e mode;
    assign mode = pick_mode(ana_en[i], tmr_en[i], per_en[i]);

    always_comb begin
      unique case (mode)
        MODE_ANALOG: begin oe_v[i] = 1'b0;      out_v[i] = 1'b0;       end
        MODE_TIMER:  begin oe_v[i] = tmr_oe[i]; out_v[i] = tmr_out[i]; end
        MODE_SHARED: begin oe_v[i] = per_oe[i]; out_v[i] = per_out[i]; end
        default:     begin oe_v[i] = dir_q[i];  out_v[i] = latch_q[i]; end
      endcase
    end

    assign pull_v[i] = pull_q[i] && !oe_v[i] && (mode != MODE_ANALOG);
    assign rd_v[i]   = read_bit(mode, dir_q[i], latch_q[i], synced[i]);

    // R4/R7: timer wins over shared peripheral and direction bit
    p_timer_owns_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ana_en[i] && tmr_en[i]) |-> (oe_v[i] == tmr_oe[i] && out_v[i] == tmr_out[i]));
    // R5: shared peripheral drives when only it is enabled
    p_shared_owns_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ana_en[i] && !tmr_en[i] && per_en[i]) |-> (oe_v[i] == per_oe[i]));
    // R3: analog pin is silent
    p_analog_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ana_en[i] |-> (!oe_v[i] && !out_v[i] && !pull_v[i] && !rd_v[i]));
    // R11: pull-up never fights an enabled driver
    p_pull_input_r11: assert property (@(posedge clk) disable iff (!rst_n)
      pull_v[i] |-> !oe_v[i]);
  end
endmodule

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      ana_en,
  input  logic [W-1:0]      tmr_en,
  input  logic [W-1:0]      tmr_oe,
  input  logic [W-1:0]      tmr_out,
  input  logic [W-1:0]      per_en,
  input  logic [W-1:0]      per_oe,
  input  logic [W-1:0]      per_out,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      pad_pull,
  output logic [W-1:0]      pad_slew,
  output logic [W-1:0]      pad_drive
);
  logic [W-1:0] latch_q, dir_q, pull_q, cfg_rdata, synced, port_rd;
  logic         wr_en;

  assign wr_en = bus_sel && bus_wr;

  gpio_regfile #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr),
    .wdata(bus_wdata), .latch_q(latch_q), .dir_q(dir_q), .pull_q(pull_q),
    .slew_q(pad_slew), .drive_q(pad_drive), .cfg_rdata(cfg_rdata)
  );

  gpio_sync #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(synced)
  );

  gpio_pin_mux #(.W(W)) u_mux (
    .clk(clk), .rst_n(rst_n),
    .ana_en(ana_en), .tmr_en(tmr_en), .tmr_oe(tmr_oe), .tmr_out(tmr_out),
    .per_en(per_en), .per_oe(per_oe), .per_out(per_out),
    .dir_q(dir_q), .latch_q(latch_q), .pull_q(pull_q), .synced(synced),
    .out_v(pad_out), .oe_v(pad_oe), .pull_v(pad_pull), .rd_v(port_rd)
  );

  always_comb begin
    if (!bus_sel)                bus_rdata = '0;
    else if (bus_addr == A_DATA) bus_rdata = port_rd;
    else                         bus_rdata = cfg_rdata;
  end

  // R2: idle bus returns zero
  p_idle_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> bus_rdata == '0);
  // R8: data read of a plain GPIO output pin returns its latch
  for (genvar i = 0; i < W; i++) begin : g_chk
    p_read_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_addr == A_DATA && !ana_en[i] && !tmr_en[i] && !per_en[i]
       && dir_q[i]) |-> bus_rdata[i] == latch_q[i]);
  end
endmodule

// File: tb/sim_gpio_port_ovr.sv
module sim_gpio_port_ovr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 0, bus_wr = 0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] ana_en = '0, tmr_en = '0, tmr_oe = '0, tmr_out = '0;
  logic [7:0] per_en = '0, per_oe = '0, per_out = '0, pad_in = '0;
  logic [7:0] pad_out, pad_oe, pad_pull, pad_slew, pad_drive;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  gpio_port_ovr u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ana_en(ana_en), .tmr_en(tmr_en), .tmr_oe(tmr_oe), .tmr_out(tmr_out),
    .per_en(per_en), .per_oe(per_oe), .per_out(per_out), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull(pad_pull),
    .pad_slew(pad_slew), .pad_drive(pad_drive)
  );

  typedef struct packed {
    logic [7:0] ana, tmr, toe, tout, per, poe, pout, dir, dat, pul;
    logic [7:0] eoe, eout, epul, erd;
  } vec_t;

  // pad_in held at 8'h0F for every row
  localparam vec_t VT [6] = '{
    '{8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'hF0,8'hAA,8'hFF, 8'hF0,8'hAA,8'h0F,8'hAF},
    '{8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF, 8'h00,8'h00,8'h00,8'h00},
    '{8'h00,8'hFF,8'h0F,8'h33,8'hFF,8'hF0,8'hCC,8'hFF,8'h00,8'hFF, 8'h0F,8'h33,8'hF0,8'h0F},
    '{8'h00,8'h00,8'h00,8'h00,8'hFF,8'h3C,8'h5A,8'h00,8'hFF,8'hFF, 8'h3C,8'h5A,8'hC3,8'h0F},
    '{8'h03,8'h0C,8'hFF,8'hFF,8'h30,8'hFF,8'h00,8'hC0,8'h80,8'hFF, 8'hFC,8'h8C,8'h00,8'h8C},
    '{8'h81,8'h42,8'h00,8'hFF,8'h24,8'h20,8'h20,8'h18,8'hFF,8'hFF, 8'h38,8'h7A,8'h46,8'h1E}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_sel = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R1: reset state
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v); check("R1 reg", v, 8'h00);
    end
    check("R1 oe", pad_oe, 8'h00);
    check("R1 pull", pad_pull, 8'h00);

    // table walk: R3..R8, R11
    pad_in = 8'h0F;
    foreach (VT[k]) begin
      wr(3'd1, VT[k].dir); wr(3'd0, VT[k].dat); wr(3'd2, VT[k].pul);
      @(negedge clk);
      ana_en = VT[k].ana; tmr_en = VT[k].tmr; tmr_oe = VT[k].toe; tmr_out = VT[k].tout;
      per_en = VT[k].per; per_oe = VT[k].poe; per_out = VT[k].pout;
      repeat (2) @(negedge clk);
      check("R3-R7 oe row", pad_oe, VT[k].eoe);
      check("R3-R7 out row", pad_out, VT[k].eout);
      check("R11 pull row", pad_pull, VT[k].epul);
      rd(3'd0, v); check("R8 read row", v, VT[k].erd);
    end

    // R2: readback and unmapped addresses
    ana_en = 0; tmr_en = 0; per_en = 0;
    wr(3'd1, 8'h96); wr(3'd2, 8'h69); wr(3'd3, 8'hA5); wr(3'd4, 8'h3C);
    wr(3'd5, 8'hFF); wr(3'd7, 8'hFF);
    rd(3'd1, v); check("R2 dir", v, 8'h96);
    rd(3'd2, v); check("R2 pull", v, 8'h69);
    rd(3'd3, v); check("R2 slew", v, 8'hA5);
    rd(3'd4, v); check("R2 drive", v, 8'h3C);
    rd(3'd5, v); check("R2 unmapped", v, 8'h00);
    #1 check("R2 idle", bus_rdata, 8'h00);
    // R12: pad controls follow registers in any mode
    ana_en = 8'h0F; tmr_en = 8'hF0;
    #1 check("R12 slew", pad_slew, 8'hA5);
    check("R12 drive", pad_drive, 8'h3C);

    // R9: two-edge synchronization
    ana_en = 0; tmr_en = 0;
    wr(3'd1, 8'h00);
    @(negedge clk); pad_in = 8'hF0;
    @(negedge clk); rd(3'd0, v); check("R9 one edge", v, 8'h0F);
    @(negedge clk); rd(3'd0, v); check("R9 two edges", v, 8'hF0);

    // R10: latch write under timer override, then release
    wr(3'd1, 8'hFF);
    @(negedge clk); tmr_en = 8'hFF; tmr_oe = 8'hFF; tmr_out = 8'h00;
    wr(3'd0, 8'h5A);
    #1 check("R10 held", pad_out, 8'h00);
    @(negedge clk); tmr_en = 8'h00;
    #1 check("R10 release", pad_out, 8'h5A);
    check("R6 oe", pad_oe, 8'hFF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule